// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle Preamble and Break Generation

This block serialises bytes onto a single transmit line. Software-side logic drops a word into a one-entry holding register. On a bit-rate strobe, the word moves into a shift register and goes out as a frame: a low start bit, the data least significant bit first, and a high stop bit. The data is 8 bits, or 9 when the wide-data select is high. A data-register-empty flag tells the writer when the next word may be supplied. A transmission-complete flag tells it when the line has gone quiet with nothing left to send.

Two extra character types ride on the same shift register. Turning the transmit enable on queues one idle preamble, an all-ones character as long as a normal frame, so the receiver sees a clean marking line first. Holding the break request streams all-zero break characters. After the request drops, the transmitter inserts one forced high bit before anything else follows. The break length is set by the data-length select and the long-break select.

Baud-rate generation is outside the block: it consumes a single-cycle strobe, one per bit time, and every line transition happens on such a strobe.

Top module: `uart_brk_tx`

## Requirements
- R1: The line output is 1 out of reset and whenever no character is in the shift register, and it changes only on a clock edge where the bit strobe is high.
- R2: A data frame is one 0 start bit, then data bits least significant first, then one 1 stop bit. There are 8 data bits (10 bit times) when the wide select is 0, or 9 data bits (11 bit times) when it is 1. Write-data bit 8 is ignored in 8-bit mode.
- R3: Dropping the enable during a frame lets that frame finish. While the enable is low, a written word stays in the holding register and is not sent.
- R4: A 0-to-1 change of the enable queues one preamble. The preamble goes out before the next data frame and is sent only once per enable change.
- R5: A preamble is all 1s with no start or stop bit, and lasts 10 bit times in 8-bit mode or 11 in 9-bit mode.
- R6: While the break request and enable are both high, break characters of all 0s are loaded back to back with no gap.
- R7: A break lasts 10 or 11 bit times (8- or 9-bit mode) with long-break off, and 13 or 14 bit times with it on.
- R8: After the last break character, exactly one forced 1 bit is sent. A pending data frame starts right after that bit.
- R9: The empty flag goes low on the cycle after a write, and rises on the strobe edge that moves the word into the shift register. A word written after that follows the current frame with no idle bit between them.
- R10: The complete flag is 1 only when the shift register and holding register are empty and no preamble or break is pending. When it is 1, the line is 1 and the empty flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| tx_en | input | 1 | Transmit enable; a rising change queues a preamble |
| brk_req | input | 1 | Level request to stream break characters |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| long_brk | input | 1 | 1 lengthens each break by LONG_EXTRA bit times |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W+1 | Word to send; top bit used only in 9-bit mode |
| txd | output | 1 | Serial line, idle high |
| tdre | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |

## Verification
The bench targets back-to-back loading. It checks the preamble-to-data and data-to-data seams, where a design that waits an extra strobe before reloading would slip an idle bit into the stream. It also checks that breaks repeat while the request stays high, and that exactly one high bit follows the last break before a queued frame. A design that drops that bit would make the next start bit invisible; one that aborts on enable removal would truncate a frame. The bench also covers a word written while disabled, which must wait and then go out behind a fresh preamble. It checks preamble and break lengths in both data widths, since an off-by-one count shows up as a shifted start bit.

// File: rtl/uart_brk_tx_pkg.sv
package uart_brk_tx_pkg;

   typedef enum logic [2:0] {
      CH_NONE,
      CH_DATA,
      CH_PRE,
      CH_BRK,
      CH_MARK
   } char_kind_t;

   // Bit-time length of one character of the given kind
   function automatic int unsigned char_bits(char_kind_t k, int unsigned dw,
                                             logic wide, logic lng,
                                             int unsigned extra);
      int unsigned base;
      base = dw + 2 + (wide ? 1 : 0);
      case (k)
         CH_DATA, CH_PRE: return base;
         CH_BRK:          return base + (lng ? extra : 0);
         CH_MARK:         return 1;
         default:         return 0;
      endcase
   endfunction

endpackage

// File: rtl/uart_brk_tx_hold.sv
module uart_brk_tx_hold #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         take,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] hold_q,
   output logic         full
);
   // A write in the same cycle as a take wins: the old word leaves, the new one stays
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         full   <= 1'b0;
      end else begin
         if (wr_en) hold_q <= wr_data;
         if (wr_en)      full <= 1'b1;
         else if (take)  full <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_brk_tx_pack.sv
module uart_brk_tx_pack
   import uart_brk_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int LONG_EXTRA = 3,
   parameter int SH_W       = 14,
   parameter int CNT_W      = 4
) (
   input  char_kind_t        kind,
   input  logic [DATA_W:0]   data,
   input  logic              wide,
   input  logic              lng,
   output logic [SH_W-1:0]   vec,
   output logic [CNT_W-1:0]  len
);
   logic [SH_W-1:0] frame_v;

   // Frame image, bit 0 leaves first: start, data, optional top bit, stop, fill
   generate
      for (genvar i = 0; i < SH_W; i++) begin : g_bit
         if (i == 0) begin : g_start
            assign frame_v[i] = 1'b0;
         end else if (i <= DATA_W) begin : g_data
            assign frame_v[i] = data[i-1];
         end else if (i == DATA_W + 1) begin : g_top
            assign frame_v[i] = wide ? data[DATA_W] : 1'b1;
         end else begin : g_fill
            assign frame_v[i] = 1'b1;
         end
      end
   endgenerate

   always_comb begin
      case (kind)
         CH_DATA: vec = frame_v;
         CH_BRK:  vec = '0;
         default: vec = '1;
      endcase
      len = CNT_W'(char_bits(kind, DATA_W, wide, lng, LONG_EXTRA));
   end
endmodule

// File: rtl/uart_brk_tx_shift.sv
module uart_brk_tx_shift #(
   parameter int SH_W  = 14,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [SH_W-1:0]  vec,
   input  logic [CNT_W-1:0] len,
   output logic             txd,
   output logic             free,
   output logic             busy
);
   logic [SH_W-1:0]  sreg;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreg <= '1;
         cnt  <= '0;
      end else if (tick) begin
         if (load) begin
            sreg <= vec;
            cnt  <= len;
         end else if (cnt != '0) begin
            sreg <= {1'b1, sreg[SH_W-1:1]};
            cnt  <= cnt - 1'b1;
         end
      end
   end

   assign busy = (cnt != '0);
   assign free = (cnt <= CNT_W'(1));
   assign txd  = busy ? sreg[0] : 1'b1;
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
   import uart_brk_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int LONG_EXTRA = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              tx_en,
   input  logic              brk_req,
   input  logic              nine_bit,
   input  logic              long_brk,
   input  logic              wr_en,
   input  logic [DATA_W:0]   wr_data,
   output logic              txd,
   output logic              tdre,
   output logic              tc
);
   localparam int SH_W  = DATA_W + 3 + LONG_EXTRA;
   localparam int CNT_W = $clog2(SH_W + 1);

   generate
      if (DATA_W < 4 || DATA_W > 16) begin : g_bad_dw
         $error("uart_brk_tx: DATA_W out of range");
      end
      if (LONG_EXTRA < 0 || LONG_EXTRA > 8) begin : g_bad_ext
         $error("uart_brk_tx: LONG_EXTRA out of range");
      end
   endgenerate

   logic             en_q, pre_pend, hold_full, take, load, free, busy;
   logic             rise, pre_eff, brk_go, after_brk;
   logic [DATA_W:0]  hold_q;
   logic [SH_W-1:0]  vec;
   logic [CNT_W-1:0] len;
   char_kind_t       next_kind, cur_kind;

   uart_brk_tx_hold #(.W(DATA_W + 1)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .take(take),
      .wr_data(wr_data), .hold_q(hold_q), .full(hold_full)
   );

   uart_brk_tx_pack #(.DATA_W(DATA_W), .LONG_EXTRA(LONG_EXTRA),
                      .SH_W(SH_W), .CNT_W(CNT_W)) u_pack (
      .kind(next_kind), .data(hold_q), .wide(nine_bit), .lng(long_brk),
      .vec(vec), .len(len)
   );

   uart_brk_tx_shift #(.SH_W(SH_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick(bit_tick), .load(load),
      .vec(vec), .len(len), .txd(txd), .free(free), .busy(busy)
   );

   assign rise      = tx_en & ~en_q;
   assign pre_eff   = pre_pend | rise;
   assign brk_go    = brk_req & tx_en;
   assign after_brk = busy && (cur_kind == CH_BRK);

   // Next-character arbitration, evaluated on the strobe that ends the current one
   always_comb begin
      next_kind = CH_NONE;
      if (bit_tick && free) begin
         if (after_brk && !brk_go)      next_kind = CH_MARK;
         else if (brk_go)               next_kind = CH_BRK;
         else if (pre_eff && tx_en)     next_kind = CH_PRE;
         else if (hold_full && tx_en)   next_kind = CH_DATA;
      end
   end

   assign load = (next_kind != CH_NONE);
   assign take = (next_kind == CH_DATA);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         pre_pend <= 1'b0;
         cur_kind <= CH_NONE;
      end else begin
         en_q     <= tx_en;
         pre_pend <= pre_eff & (next_kind != CH_PRE);
         if (load) cur_kind <= next_kind;
      end
   end

   assign tdre = ~hold_full;
   assign tc   = ~busy & ~hold_full & ~pre_pend & ~brk_go;
endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_tick,
   input logic tx_en,
   input logic brk_req,
   input logic wr_en,
   input logic txd,
   input logic tdre,
   input logic tc
);
   assert_line_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(txd) |-> $past(bit_tick));

   assert_empty_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tdre) |-> $past(bit_tick));

   assert_write_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !tdre);

   assert_complete_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> (txd && tdre));

   assert_complete_no_break_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> !(brk_req && tx_en));
endmodule

bind uart_brk_tx uart_brk_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
   .brk_req(brk_req), .wr_en(wr_en), .txd(txd), .tdre(tdre), .tc(tc)
);

// File: tb/tb_uart_brk_tx.sv
module tb_uart_brk_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick;
   logic       tx_en = 1'b0, brk_req = 1'b0, nine_bit = 1'b0, long_brk = 1'b0;
   logic       wr_en = 1'b0;
   logic [8:0] wr_data = '0;
   logic       txd, tdre, tc;
   logic [1:0] tcnt;
   int         n_chk = 0, n_fail = 0;
   bit         exp_q[$];
   string      cur_req = "R1";
   bit         done = 1'b0;

   always #2 clk = ~clk;

   always_ff @(posedge clk) begin
      if (!rst_n) tcnt <= '0;
      else        tcnt <= tcnt + 1'b1;
   end
   assign bit_tick = (tcnt == 2'd3);

   uart_brk_tx dut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
      .brk_req(brk_req), .nine_bit(nine_bit), .long_brk(long_brk),
      .wr_en(wr_en), .wr_data(wr_data), .txd(txd), .tdre(tdre), .tc(tc)
   );

   function automatic void chk(string req, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endfunction

   // Monitor: one line sample per bit period, compared against the scoreboard
   always @(negedge clk) begin
      if (rst_n && tcnt == 2'd1) begin
         if (exp_q.size() != 0) chk(cur_req, "line bit", txd, exp_q.pop_front());
         else                   chk("R1", "idle line", txd, 1'b1);
      end
   end

   task automatic step();
      do @(negedge clk); while (tcnt != 2'd2);
   endtask

   task automatic write(input logic [8:0] d);
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
      chk("R9", "empty low after write", tdre, 1'b0);
   endtask

   function automatic void push_ones(int n);
      for (int i = 0; i < n; i++) exp_q.push_back(1'b1);
   endfunction

   function automatic void push_zeros(int n);
      for (int i = 0; i < n; i++) exp_q.push_back(1'b0);
   endfunction

   function automatic void push_frame(logic [8:0] d, logic wide);
      exp_q.push_back(1'b0);
      for (int i = 0; i < 8; i++) exp_q.push_back(d[i]);
      if (wide) exp_q.push_back(d[8]);
      exp_q.push_back(1'b1);
   endfunction

   task automatic drain();
      while (exp_q.size() != 0) step();
      step();
      chk("R10", "complete after drain", tc, 1'b1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset line", txd, 1'b1);
      chk("R10", "reset empty", tdre, 1'b1);
      chk("R10", "reset complete", tc, 1'b1);

      // R4/R5: enable rise queues 10-bit preamble, then frame; R2 bit 8 ignored
      step();
      cur_req = "R4";
      tx_en = 1'b1;
      push_ones(10);
      push_frame(9'h0A5, 1'b0);
      write(9'h1A5);
      while (!tdre) step();
      // R9: next word follows with no idle bit
      cur_req = "R9";
      push_frame(9'h03C, 1'b0);
      write(9'h03C);
      drain();

      // R2: 9-bit frame, no second preamble while enable stays high
      step();
      cur_req = "R2";
      nine_bit = 1'b1;
      push_frame(9'h15A, 1'b1);
      write(9'h15A);
      drain();

      // R5: toggled enable gives an 11-bit preamble in 9-bit mode
      step();
      tx_en = 1'b0;
      step();
      cur_req = "R5";
      tx_en = 1'b1;
      push_ones(11);
      step();
      push_frame(9'h0C3, 1'b1);
      write(9'h0C3);
      drain();

      // R3: disable mid-frame finishes the frame; disabled writes wait
      step();
      cur_req = "R3";
      nine_bit = 1'b0;
      push_frame(9'h081, 1'b0);
      write(9'h081);
      repeat (3) step();
      tx_en = 1'b0;
      drain();
      write(9'h042);
      repeat (15) step();
      chk("R3", "word held while disabled", tdre, 1'b0);
      chk("R10", "not complete with word held", tc, 1'b0);
      tx_en = 1'b1;
      push_ones(10);
      push_frame(9'h042, 1'b0);
      drain();

      // R6/R7/R8: two 13-bit breaks, one mark bit, then the queued frame
      step();
      cur_req = "R7";
      long_brk = 1'b1;
      brk_req = 1'b1;
      push_zeros(26);
      exp_q.push_back(1'b1);
      push_frame(9'h099, 1'b0);
      step();
      chk("R10", "not complete during break", tc, 1'b0);
      step();
      write(9'h099);
      for (int k = 3; k <= 13; k++) step();
      cur_req = "R6";
      step();
      brk_req = 1'b0;
      cur_req = "R8";
      drain();

      // R7/R8: single 11-bit break in 9-bit mode without long select, then mark
      step();
      cur_req = "R7";
      nine_bit = 1'b1;
      long_brk = 1'b0;
      brk_req = 1'b1;
      push_zeros(11);
      exp_q.push_back(1'b1);
      step();
      brk_req = 1'b0;
      drain();
      repeat (3) step();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule